// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block walks a 16-entry register mask and issues one word-wide memory request for each selected register. The requests go out lowest register index first, at addresses that rise by four bytes each time. A command supplies the base address, the mask, a two-bit direction/timing mode, a base-update flag, a load/store flag and a privileged-bank flag. The sequencer works out the first address from the number of selected registers. It then emits each (register index, address) pair on a valid/ready request port, holding each one until it is accepted.

When the last request has been accepted, the block raises a single-cycle completion strobe. The strobe carries the updated base value, and three side flags go with it: base update wanted, status-register restore, and program-counter redirect. During the transfer a bank-select output tells the register file whether to use the user-mode bank. The register file, the memory and the instruction decode sit around this block and are not part of it.

Top module: `blkxfer_seq`

## Requirements
- R1: The number of accepted requests for a command equals the number of ones in `cmd_list`. A command with an all-zero mask produces no request.
- R2: Mode 0 (ascending, update after) starts at `cmd_base`.
- R3: Mode 1 (ascending, update before) starts at `cmd_base + 4`.
- R4: Mode 2 (descending, update after) starts at `cmd_base - 4*n + 4`, where n is the number of ones in the mask. Address arithmetic wraps modulo 2^32.
- R5: Mode 3 (descending, update before) starts at `cmd_base - 4*n`.
- R6: Registers are visited from index 0 upward, skipping clear bits. Each accepted request is followed by the next index at the address plus 4.
- R7: While `req_valid` is high and `req_ready` is low, `req_addr`, `req_reg` and `req_user_bank` hold their values, and `req_valid` stays high.
- R8: `done` is high for exactly one cycle. That cycle is the one after the last accepted request, or the one after command capture when the mask is empty.
- R9: `wb_valid` is high in the `done` cycle exactly when `cmd_wb` was set. In that cycle `wb_value` is `cmd_base + 4*n` for modes 0/1 and `cmd_base - 4*n` for modes 2/3.
- R10: `psr_restore` is high in the `done` cycle exactly when the command was a load (`cmd_load`=1) with `cmd_sbit`=1 and mask bit 15 set.
- R11: `req_user_bank` is high on every request when `cmd_sbit`=1, except on a load whose mask has bit 15 set. `req_write` is the inverse of `cmd_load`.
- R12: `pc_redirect` is high in the `done` cycle exactly when the command was a load with mask bit 15 set.
- R13: After reset `busy`, `req_valid` and `done` are low. A `cmd_valid` arriving while `busy` is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, captured only while idle |
| cmd_base | input | 32 | Base address |
| cmd_list | input | 16 | Register mask, bit i selects register i |
| cmd_mode | input | 2 | 0 asc-after, 1 asc-before, 2 desc-after, 3 desc-before |
| cmd_wb | input | 1 | Base update requested |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_sbit | input | 1 | Privileged-bank / status-restore flag |
| busy | output | 1 | Command in progress |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Word address of the request |
| req_reg | output | 4 | Register index of the request |
| req_write | output | 1 | Request is a store |
| req_user_bank | output | 1 | Use the user-mode register bank |
| done | output | 1 | Single-cycle completion strobe |
| wb_valid | output | 1 | Base update valid (with done) |
| wb_value | output | 32 | New base value |
| psr_restore | output | 1 | Copy saved status to current status (with done) |
| pc_redirect | output | 1 | Program counter was loaded (with done) |

## Verification
The hardest cases to reach are the ones where the request port stalls in the middle of a sequence. These are the only cases where R7's holding behaviour and the index/address pairing can drift apart. The bench therefore drives `req_ready` from a pseudo-random pattern on selected commands, and a full 16-register mask gives long stall runs. A second hard case is a command that arrives while busy. The bench injects a conflicting command one cycle after a real one and checks that the scoreboard still matches the original sequence. A descending mode on a base near zero covers the address wrap.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    AM_ASC_AFTER   = 2'd0,
    AM_ASC_BEFORE  = 2'd1,
    AM_DESC_AFTER  = 2'd2,
    AM_DESC_BEFORE = 2'd3
  } am_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } st_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int W   = 16,
  parameter int CW  = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          single
);
  logic [W-1:0] iso;
  assign iso = vec & (~vec + W'(1));

  genvar b;
  generate
    for (b = 0; b < IW; b++) begin : g_bit
      logic [W-1:0] sel;
      always_comb begin
        sel = '0;
        for (int i = 0; i < W; i++) sel[i] = ((i >> b) & 1) == 1;
      end
      assign idx[b] = |(iso & sel);
    end
  endgenerate

  assign single = (vec != '0) && ((vec & (vec - W'(1))) == '0);
endmodule

// File: rtl/blkxfer_addr.sv
module blkxfer_addr
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  am_e               mode,
  input  logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] first,
  output logic [ADDR_W-1:0] final_base
);
  function automatic logic [ADDR_W-1:0] span(input logic [CNT_W-1:0] n);
    return ADDR_W'(n) * ADDR_W'(STEP);
  endfunction

  always_comb begin
    unique case (mode)
      AM_ASC_AFTER:   first = base;
      AM_ASC_BEFORE:  first = base + ADDR_W'(STEP);
      AM_DESC_AFTER:  first = base - span(cnt) + ADDR_W'(STEP);
      default:        first = base - span(cnt);
    endcase
    final_base = (mode == AM_ASC_AFTER || mode == AM_ASC_BEFORE)
               ? base + span(cnt) : base - span(cnt);
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int LIST_W = 16,
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [ADDR_W-1:0]         cmd_base,
  input  logic [LIST_W-1:0]         cmd_list,
  input  logic [1:0]                cmd_mode,
  input  logic                      cmd_wb,
  input  logic                      cmd_load,
  input  logic                      cmd_sbit,
  output logic                      busy,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [ADDR_W-1:0]         req_addr,
  output logic [$clog2(LIST_W)-1:0] req_reg,
  output logic                      req_write,
  output logic                      req_user_bank,
  output logic                      done,
  output logic                      wb_valid,
  output logic [ADDR_W-1:0]         wb_value,
  output logic                      psr_restore,
  output logic                      pc_redirect
);
  localparam int IDX_W  = $clog2(LIST_W);
  localparam int CNT_W  = $clog2(LIST_W + 1);
  localparam int PC_IDX = LIST_W - 1;

  st_e                state_q;
  logic [LIST_W-1:0]  remain_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [ADDR_W-1:0]  wbv_q;
  logic               wben_q, load_q, ubank_q, psr_q, pcld_q;

  logic [CNT_W-1:0]   cmd_cnt;
  logic [ADDR_W-1:0]  first_addr, end_base;
  logic [IDX_W-1:0]   cur_idx;
  logic               cur_single;

  // named events for the checker
  logic               accept;
  logic               fire;
  logic               last_fire;
  logic               pc_in_list;

  blkxfer_popcnt #(.W(LIST_W), .CW(CNT_W)) u_cnt (
    .vec (cmd_list),
    .cnt (cmd_cnt)
  );

  blkxfer_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) u_addr (
    .base       (cmd_base),
    .mode       (am_e'(cmd_mode)),
    .cnt        (cmd_cnt),
    .first      (first_addr),
    .final_base (end_base)
  );

  blkxfer_lowbit #(.W(LIST_W), .IW(IDX_W)) u_low (
    .vec    (remain_q),
    .idx    (cur_idx),
    .single (cur_single)
  );

  assign pc_in_list = cmd_list[PC_IDX];
  assign accept     = cmd_valid && (state_q == ST_IDLE);
  assign req_valid  = (state_q == ST_BUSY);
  assign fire       = req_valid && req_ready;
  assign last_fire  = fire && cur_single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      addr_q   <= '0;
      wbv_q    <= '0;
      wben_q   <= 1'b0;
      load_q   <= 1'b0;
      ubank_q  <= 1'b0;
      psr_q    <= 1'b0;
      pcld_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          remain_q <= cmd_list;
          addr_q   <= first_addr;
          wbv_q    <= end_base;
          wben_q   <= cmd_wb;
          load_q   <= cmd_load;
          ubank_q  <= cmd_sbit && !(cmd_load && pc_in_list);
          psr_q    <= cmd_sbit && cmd_load && pc_in_list;
          pcld_q   <= cmd_load && pc_in_list;
          state_q  <= (cmd_list == '0) ? ST_DONE : ST_BUSY;
        end
        ST_BUSY: if (fire) begin
          remain_q <= remain_q & ~(LIST_W'(1) << cur_idx);
          addr_q   <= addr_q + ADDR_W'(STEP);
          if (cur_single) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign req_addr      = addr_q;
  assign req_reg       = cur_idx;
  assign req_write     = !load_q;
  assign req_user_bank = ubank_q;
  assign done          = (state_q == ST_DONE);
  assign wb_valid      = done && wben_q;
  assign wb_value      = wbv_q;
  assign psr_restore   = done && psr_q;
  assign pc_redirect   = done && pcld_q;
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [IDX_W-1:0]  req_reg,
  input logic              req_user_bank,
  input logic              done,
  input logic              last_fire,
  input logic              wb_valid,
  input logic              psr_restore,
  input logic              pc_redirect
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !last_fire) |=> (req_valid && req_addr == $past(req_addr) + ADDR_W'(STEP))); // R6
  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !last_fire) |=> (req_reg > $past(req_reg))); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_reg) && $stable(req_user_bank))); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done); // R9
  AST_PSR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    psr_restore |-> (done && pc_redirect)); // R10
  AST_PC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> done); // R12
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R13
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R13
endmodule

bind blkxfer_seq blkxfer_chk u_chk (.*);

// File: tb/test_blkxfer_seq.sv
module test_blkxfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_list = '0;
  logic [1:0]  cmd_mode = '0;
  logic        cmd_wb = 1'b0, cmd_load = 1'b0, cmd_sbit = 1'b0;
  logic        busy, req_valid, req_write, req_user_bank;
  logic        req_ready = 1'b1;
  logic [31:0] req_addr, wb_value;
  logic [3:0]  req_reg;
  logic        done, wb_valid, psr_restore, pc_redirect;

  blkxfer_seq i_blkxfer_seq (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic [3:0] r; logic [31:0] a; } item_t;
  item_t q[$];

  int tests = 0, fails = 0;
  int cyc = 0, cmd_cyc = 0, last_acc = -1, done_cnt = 0;
  logic stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic exp_wbv, exp_psr, exp_pc, exp_ub, exp_wr;
  logic [31:0] exp_wbval;
  logic hold_f = 1'b0;
  logic [31:0] hold_a;
  logic [3:0]  hold_r;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected requests and checks completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_en) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        req_ready = lfsr[0];
      end else req_ready = 1'b1;
      if (hold_f) begin
        chk(req_valid && req_addr == hold_a && req_reg == hold_r, "R7 stall hold", req_addr, hold_a);
        hold_f = 1'b0;
      end
      if (req_valid && !req_ready) begin
        hold_f = 1'b1; hold_a = req_addr; hold_r = req_reg;
      end
      if (req_valid && req_ready) begin
        if (q.size() == 0) chk(0, "R1 extra request", {28'd0, req_reg}, 32'd0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(req_reg == it.r, "R6 register order", {28'd0, req_reg}, {28'd0, it.r});
          chk(req_addr == it.a, "R2-5/R6 address", req_addr, it.a);
          chk(req_user_bank == exp_ub, "R11 user bank", {31'd0, req_user_bank}, {31'd0, exp_ub});
          chk(req_write == exp_wr, "R11 direction", {31'd0, req_write}, {31'd0, exp_wr});
        end
        last_acc = cyc;
      end
      if (done) begin
        chk(q.size() == 0, "R1 missing requests", q.size(), 32'd0);
        chk(cyc == ((last_acc < 0) ? cmd_cyc + 1 : last_acc + 1), "R8 done timing", cyc, (last_acc < 0) ? cmd_cyc + 1 : last_acc + 1);
        chk(wb_valid == exp_wbv, "R9 wb flag", {31'd0, wb_valid}, {31'd0, exp_wbv});
        chk(wb_value == exp_wbval, "R9 wb value", wb_value, exp_wbval);
        chk(psr_restore == exp_psr, "R10 status restore", {31'd0, psr_restore}, {31'd0, exp_psr});
        chk(pc_redirect == exp_pc, "R12 pc redirect", {31'd0, pc_redirect}, {31'd0, exp_pc});
        done_cnt++;
      end
    end
  end

  // driver: computes the expected sequence, then issues the command
  task automatic run(input logic [31:0] base, input logic [15:0] list, input logic [1:0] mode,
                     input logic wb, input logic ld, input logic s, input logic stall, input logic poke);
    int n = 0;
    logic [31:0] a;
    int prev;
    for (int i = 0; i < 16; i++) if (list[i]) n++;
    case (mode)
      2'd0: a = base;
      2'd1: a = base + 32'd4;
      2'd2: a = base + 32'd4 - 32'(4 * n);
      default: a = base - 32'(4 * n);
    endcase
    for (int i = 0; i < 16; i++) if (list[i]) begin
      item_t it;
      it.r = 4'(i); it.a = a;
      q.push_back(it);
      a = a + 32'd4;
    end
    exp_wbval = (mode < 2) ? base + 32'(4 * n) : base - 32'(4 * n);
    exp_wbv = wb;
    exp_pc  = ld && list[15];
    exp_psr = ld && s && list[15];
    exp_ub  = s && !(ld && list[15]);
    exp_wr  = !ld;
    last_acc = -1;
    prev = done_cnt;
    @(negedge clk);
    stall_en = stall;
    cmd_base = base; cmd_list = list; cmd_mode = mode;
    cmd_wb = wb; cmd_load = ld; cmd_sbit = s; cmd_valid = 1'b1;
    cmd_cyc = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      // R13: conflicting command while busy must be ignored
      cmd_base = 32'hDEAD0000; cmd_list = 16'h0001; cmd_mode = 2'd3;
      cmd_load = ~ld; cmd_sbit = ~s; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait (done_cnt != prev);
    @(negedge clk);
    chk(!busy && !req_valid, "R13 idle after done", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid && !done, "R13 reset state", {29'd0, busy, req_valid, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'h0000_1000, 16'h00F1, 2'd0, 1, 1, 0, 0, 0); // R2
    run(32'h0000_2000, 16'h8421, 2'd1, 0, 0, 0, 1, 0); // R3 with stalls
    run(32'h0000_3000, 16'hFFFF, 2'd2, 1, 1, 1, 1, 0); // R4, R10, R12, stalls
    run(32'h0000_0040, 16'h0006, 2'd3, 1, 0, 1, 0, 0); // R5, R11 store
    run(32'h0000_0004, 16'h0003, 2'd3, 1, 1, 0, 0, 0); // R5 wrap below zero
    run(32'h0000_5000, 16'h0000, 2'd3, 1, 1, 1, 0, 0); // R1/R8 empty mask
    run(32'h0000_6000, 16'h7000, 2'd0, 0, 1, 1, 1, 0); // R11 load S without r15
    run(32'h0000_7000, 16'h8003, 2'd1, 1, 0, 1, 0, 0); // R11 store S with r15
    run(32'h0000_8000, 16'h0F0F, 2'd0, 1, 1, 0, 0, 1); // R13 poke while busy
    run(32'h0000_9000, 16'h8000, 2'd2, 0, 1, 0, 1, 0); // R12 single r15 load
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule